// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the per-source state of a small group of interrupt sources whose global numbers start at a configurable base. Each source has a destination server, a current priority, a saved priority, a fixed kind (level-sensitive or message-signalled) and a few status flags. The block turns source activity and presenter feedback into presentations, each carrying server, global number and priority. The value 0xFF is the masked priority.

Configuration commands write or read an entry. There are four: program server and priority, read back, mask while saving the priority, and restore the saved priority. Each command gets a one-cycle response with an error flag. The presenter can return rejects, end-of-interrupt notices and a global resend request. From these the block decides which sources must be offered again. Presentations leave one per cycle, lowest index first.

Top module: `isc_src_ctrl`

## Requirements
- R1: A global number n addresses a source only when BASE <= n < BASE+NUM_SRC, and it then selects local index n-BASE. Every presentation reports pres_num = BASE + local index. Commands, rejects and EOIs that carry any other number change nothing.
- R2: After reset, every source has server 0, priority 0xFF, saved priority 0xFF and all flags clear. No presentation and no response is pending.
- R3: A message event is an event on a message source with evt_level=1. If the source priority is 0xFF, the event sets the masked-pending flag and is not presented. Otherwise the source is presented.
- R4: A program command (cmd_op=0) on a message source writes the server, and writes the priority into both the priority and the saved priority. If masked-pending was set and the new priority is not 0xFF, masked-pending is cleared and the source is presented once.
- R5: A level event copies evt_level into the asserted flag. On a 0-to-1 change, an unmasked source whose sent flag is clear is presented and its sent flag is set. No further presentation happens while sent stays set.
- R6: A program command on a level source performs the same write as R4. It then presents the source and sets sent if the new priority is not 0xFF, the source is asserted and sent is clear.
- R7: A reject of a message source sets its rejected flag, and a reject of a level source clears sent. On resend, a rejected message source has the flag cleared and is presented if unmasked. On resend, a level source is handled as in R6.
- R8: An EOI of a level source clears sent and then applies the R6 check. An EOI of a message source has no effect.
- R9: A program command returns rsp_err=1 and changes nothing in three cases: the number is out of range, cmd_server >= NUM_SERVERS, or cmd_prio > 0xFF.
- R10: Mask (cmd_op=2) stores the current priority as the saved priority and sets the priority to 0xFF. Restore (cmd_op=3) copies the saved priority into both fields and then applies the R4/R6 presentation rules. Masking twice therefore leaves the saved priority at 0xFF. Both commands fail only on an out-of-range number.
- R11: Read (cmd_op=1) returns the server and priority of a valid source, or rsp_err=1 with zero data for an invalid number. Every command gets rsp_valid exactly one cycle later. Responses to commands other than read carry zero data.
- R12: A presentation is due two cycles after its stimulus, at most one per cycle, lowest pending index first. It carries the server and priority held at that time. A pending presentation whose source has become masked is dropped.
- R13: Only one action is serviced per cycle, in this priority: command, reject, EOI, source event, resend. Lower-priority inputs in the same cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Source line event strobe |
| evt_idx | input | IDX_W | Local index of the source |
| evt_level | input | 1 | New line level (message sources fire on 1) |
| cmd_valid | input | 1 | Configuration command strobe |
| cmd_op | input | 2 | 0 program, 1 read, 2 mask, 3 restore |
| cmd_num | input | NUM_W | Global interrupt number |
| cmd_server | input | SRV_W | Server index for program |
| cmd_prio | input | PRIO_W+1 | Priority for program (extra bit detects >0xFF) |
| rsp_valid | output | 1 | Command response strobe |
| rsp_err | output | 1 | Parameter error |
| rsp_server | output | SRV_W | Read-back server |
| rsp_prio | output | PRIO_W | Read-back priority |
| rej_valid | input | 1 | Presenter reject strobe |
| rej_num | input | NUM_W | Rejected global number |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend_valid | input | 1 | Resend request for all sources |
| pres_valid | output | 1 | Presentation strobe |
| pres_num | output | NUM_W | Presented global number |
| pres_server | output | SRV_W | Destination server |
| pres_prio | output | PRIO_W | Presented priority |

## Verification
A command sampled on one rising edge has its response on the outputs from that edge on, so the bench reads it at the next falling edge. A presentation needs a second edge, because the request is registered before arbitration, so it is read one falling edge later. Further presentations queued by the same stimulus follow at one-cycle spacing. The bench drives every input at a falling edge and places each directed check at exactly that offset. A behavioural model advances on each rising edge and is compared with all outputs at every falling edge, so an early, late or missing result is caught in the cycle it occurs.

// File: rtl/isc_pkg.sv
`timescale 1ns/1ps
package isc_pkg;
  typedef enum logic [1:0] {
    CMD_SET = 2'd0,
    CMD_GET = 2'd1,
    CMD_OFF = 2'd2,
    CMD_ON  = 2'd3
  } isc_cmd_e;

  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_WRITE  = 3'd1,
    ACT_REJECT = 3'd2,
    ACT_EOI    = 3'd3,
    ACT_EVT    = 3'd4,
    ACT_RESEND = 3'd5
  } isc_act_e;

  typedef struct packed {
    logic rejected;
    logic asserted;
    logic sent;
    logic mpend;
  } isc_stat_t;
endpackage

// File: rtl/isc_entry.sv
`timescale 1ns/1ps
module isc_entry
  import isc_pkg::*;
#(
  parameter int SRV_W    = 4,
  parameter int PRIO_W   = 8,
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  isc_act_e          act,
  input  logic              evt_level,
  input  isc_cmd_e          cmd,
  input  logic [SRV_W-1:0]  cmd_server,
  input  logic [PRIO_W-1:0] cmd_prio,
  output logic [SRV_W-1:0]  server_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic              live_o,
  output logic              present_o
);
  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic [SRV_W-1:0]  srv_q, srv_n, w_srv;
  logic [PRIO_W-1:0] pri_q, pri_n, w_pri;
  logic [PRIO_W-1:0] sav_q, sav_n, w_sav;
  isc_stat_t         st_q, st_n;
  logic              en;

  assign en = (act == ACT_RESEND) || (hit && (act != ACT_NONE));

  // values a write command would store
  always_comb begin
    unique case (cmd)
      CMD_OFF: begin w_srv = srv_q; w_pri = MASKED; w_sav = pri_q; end
      CMD_ON:  begin w_srv = srv_q; w_pri = sav_q;  w_sav = sav_q; end
      default: begin w_srv = cmd_server; w_pri = cmd_prio; w_sav = cmd_prio; end
    endcase
  end

  always_comb begin
    srv_n = srv_q;
    pri_n = pri_q;
    sav_n = sav_q;
    st_n  = st_q;
    present_o = 1'b0;
    if (en) begin
      unique case (act)
        ACT_WRITE: begin
          srv_n = w_srv;
          pri_n = w_pri;
          sav_n = w_sav;
          if (IS_LEVEL) begin
            if (w_pri != MASKED && st_q.asserted && !st_q.sent) begin
              st_n.sent = 1'b1;
              present_o = 1'b1;
            end
          end else if (st_q.mpend && w_pri != MASKED) begin
            st_n.mpend = 1'b0;
            present_o  = 1'b1;
          end
        end
        ACT_REJECT: begin
          if (IS_LEVEL) st_n.sent = 1'b0;
          else          st_n.rejected = 1'b1;
        end
        ACT_EOI: begin
          if (IS_LEVEL) begin
            st_n.sent = 1'b0;
            if (pri_q != MASKED && st_q.asserted) begin
              st_n.sent = 1'b1;
              present_o = 1'b1;
            end
          end
        end
        ACT_EVT: begin
          if (IS_LEVEL) begin
            st_n.asserted = evt_level;
            if (evt_level && !st_q.asserted && pri_q != MASKED && !st_q.sent) begin
              st_n.sent = 1'b1;
              present_o = 1'b1;
            end
          end else if (evt_level) begin
            if (pri_q == MASKED) st_n.mpend = 1'b1;
            else                 present_o  = 1'b1;
          end
        end
        ACT_RESEND: begin
          if (IS_LEVEL) begin
            if (pri_q != MASKED && st_q.asserted && !st_q.sent) begin
              st_n.sent = 1'b1;
              present_o = 1'b1;
            end
          end else if (st_q.rejected) begin
            st_n.rejected = 1'b0;
            present_o = (pri_q != MASKED);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srv_q <= '0;
      pri_q <= MASKED;
      sav_q <= MASKED;
      st_q  <= '0;
    end else if (en) begin
      srv_q <= srv_n;
      pri_q <= pri_n;
      sav_q <= sav_n;
      st_q  <= st_n;
    end
  end

  assign server_o = srv_q;
  assign prio_o   = pri_q;
  assign live_o   = (pri_q != MASKED);
endmodule

// File: rtl/isc_pick.sv
`timescale 1ns/1ps
module isc_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = |req;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/isc_src_ctrl.sv
`timescale 1ns/1ps
module isc_src_ctrl
  import isc_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int BASE        = 16,
  parameter int NUM_SERVERS = 6,
  parameter int NUM_W       = 10,
  parameter int SRV_W       = 4,
  parameter int PRIO_W      = 8,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hF0,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [IDX_W-1:0]  evt_idx,
  input  logic              evt_level,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [NUM_W-1:0]  cmd_num,
  input  logic [SRV_W-1:0]  cmd_server,
  input  logic [PRIO_W:0]   cmd_prio,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [SRV_W-1:0]  rsp_server,
  output logic [PRIO_W-1:0] rsp_prio,
  input  logic              rej_valid,
  input  logic [NUM_W-1:0]  rej_num,
  input  logic              eoi_valid,
  input  logic [NUM_W-1:0]  eoi_num,
  input  logic              resend_valid,
  output logic              pres_valid,
  output logic [NUM_W-1:0]  pres_num,
  output logic [SRV_W-1:0]  pres_server,
  output logic [PRIO_W-1:0] pres_prio
);
  isc_cmd_e          cmd_e;
  isc_act_e          act;
  logic [NUM_W-1:0]  tgt_num, tgt_off;
  logic              in_rng, cmd_bad;
  logic [NUM_SRC-1:0] hit, live, set_vec, grant, req_q, req_n;
  logic [SRV_W-1:0]  ent_srv [NUM_SRC];
  logic [PRIO_W-1:0] ent_pri [NUM_SRC];
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_any;
  logic [SRV_W-1:0]  get_srv;
  logic [PRIO_W-1:0] get_pri;

  assign cmd_e   = isc_cmd_e'(cmd_op);
  assign tgt_num = cmd_valid ? cmd_num : (rej_valid ? rej_num : eoi_num);
  assign tgt_off = tgt_num - NUM_W'(BASE);
  assign in_rng  = (tgt_num >= NUM_W'(BASE)) && (tgt_num < NUM_W'(BASE + NUM_SRC));
  assign cmd_bad = !in_rng ||
                   ((cmd_e == CMD_SET) &&
                    ((int'(cmd_server) >= NUM_SERVERS) || cmd_prio[PRIO_W]));

  // one serviced action per cycle, fixed priority
  always_comb begin
    if (cmd_valid)         act = (cmd_e != CMD_GET && !cmd_bad) ? ACT_WRITE : ACT_NONE;
    else if (rej_valid)    act = ACT_REJECT;
    else if (eoi_valid)    act = ACT_EOI;
    else if (evt_valid)    act = ACT_EVT;
    else if (resend_valid) act = ACT_RESEND;
    else                   act = ACT_NONE;
  end

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    assign hit[gi] = (act == ACT_EVT) ? (evt_idx == IDX_W'(gi))
                                      : (in_rng && (tgt_off == NUM_W'(gi)));
    isc_entry #(
      .SRV_W   (SRV_W),
      .PRIO_W  (PRIO_W),
      .IS_LEVEL(LEVEL_MASK[gi])
    ) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit[gi]),
      .act       (act),
      .evt_level (evt_level),
      .cmd       (cmd_e),
      .cmd_server(cmd_server),
      .cmd_prio  (cmd_prio[PRIO_W-1:0]),
      .server_o  (ent_srv[gi]),
      .prio_o    (ent_pri[gi]),
      .live_o    (live[gi]),
      .present_o (set_vec[gi])
    );
  end

  isc_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .req  (req_q & live),
    .grant(grant),
    .idx  (pick_idx),
    .any  (pick_any)
  );

  always_comb begin
    get_srv = '0;
    get_pri = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (hit[i]) begin
        get_srv = ent_srv[i];
        get_pri = ent_pri[i];
      end
    end
  end

  // requests of masked sources drop; a new request beats its own grant
  assign req_n = (req_q & live & ~grant) | set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q       <= '0;
      pres_valid  <= 1'b0;
      pres_num    <= '0;
      pres_server <= '0;
      pres_prio   <= '0;
      rsp_valid   <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_server  <= '0;
      rsp_prio    <= '0;
    end else begin
      req_q       <= req_n;
      pres_valid  <= pick_any;
      pres_num    <= pick_any ? NUM_W'(BASE) + NUM_W'(pick_idx) : '0;
      pres_server <= pick_any ? ent_srv[pick_idx] : '0;
      pres_prio   <= pick_any ? ent_pri[pick_idx] : '0;
      rsp_valid   <= cmd_valid;
      rsp_err     <= cmd_valid && cmd_bad;
      rsp_server  <= (cmd_valid && cmd_e == CMD_GET && !cmd_bad) ? get_srv : '0;
      rsp_prio    <= (cmd_valid && cmd_e == CMD_GET && !cmd_bad) ? get_pri : '0;
    end
  end
endmodule

// File: rtl/isc_src_ctrl_chk.sv
`timescale 1ns/1ps
module isc_src_ctrl_chk #(
  parameter int NUM_SRC     = 8,
  parameter int BASE        = 16,
  parameter int NUM_SERVERS = 6,
  parameter int NUM_W       = 10,
  parameter int SRV_W       = 4,
  parameter int PRIO_W      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [SRV_W-1:0]  cmd_server,
  input logic [PRIO_W:0]   cmd_prio,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [SRV_W-1:0]  rsp_server,
  input logic [PRIO_W-1:0] rsp_prio,
  input logic              pres_valid,
  input logic [NUM_W-1:0]  pres_num,
  input logic [PRIO_W-1:0] pres_prio,
  input logic [NUM_SRC-1:0] req_q,
  input logic [NUM_SRC-1:0] grant
);
  a_r11_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);
  a_r11_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid));
  a_r11_err_nodata: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_server == '0 && rsp_prio == '0));
  a_r9_bad_server: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && int'(cmd_server) >= NUM_SERVERS) |=> rsp_err);
  a_r9_bad_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && cmd_prio[PRIO_W]) |=> rsp_err);
  a_r1_pres_range: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> (pres_num >= NUM_W'(BASE) && pres_num < NUM_W'(BASE + NUM_SRC)));
  a_r12_pres_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> (pres_prio != '1));
  a_r12_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r12_pres_had_req: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> $past(|req_q));
endmodule

bind isc_src_ctrl isc_src_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .BASE(BASE), .NUM_SERVERS(NUM_SERVERS),
  .NUM_W(NUM_W), .SRV_W(SRV_W), .PRIO_W(PRIO_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_server(cmd_server), .cmd_prio(cmd_prio), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_server(rsp_server), .rsp_prio(rsp_prio),
  .pres_valid(pres_valid), .pres_num(pres_num), .pres_prio(pres_prio),
  .req_q(req_q), .grant(grant)
);

// File: tb/tb_isc_src_ctrl.sv
`timescale 1ns/1ps
module tb_isc_src_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       evt_valid, evt_level;
  logic [2:0] evt_idx;
  logic       cmd_valid;
  logic [1:0] cmd_op;
  logic [9:0] cmd_num;
  logic [3:0] cmd_server;
  logic [8:0] cmd_prio;
  logic       rsp_valid, rsp_err;
  logic [3:0] rsp_server;
  logic [7:0] rsp_prio;
  logic       rej_valid, eoi_valid, resend_valid;
  logic [9:0] rej_num, eoi_num;
  logic       pres_valid;
  logic [9:0] pres_num;
  logic [3:0] pres_server;
  logic [7:0] pres_prio;

  int    n_chk = 0;
  int    n_err = 0;
  bit    cmp_on = 0;
  bit    done = 0;
  string cur_tag = "R2";

  always #2.5 clk = ~clk;

  isc_src_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid), .evt_idx(evt_idx), .evt_level(evt_level),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_num(cmd_num),
    .cmd_server(cmd_server), .cmd_prio(cmd_prio),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_server(rsp_server), .rsp_prio(rsp_prio),
    .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend_valid(resend_valid),
    .pres_valid(pres_valid), .pres_num(pres_num), .pres_server(pres_server), .pres_prio(pres_prio)
  );

  // ---------------- behavioural reference ----------------
  int m_srv[8], m_pri[8], m_sav[8];
  bit m_rej[8], m_asr[8], m_snt[8], m_mp[8], m_req[8];
  int e_pv, e_pnum, e_psrv, e_ppri, e_rv, e_rerr, e_rsrv, e_rpri;

  function automatic bit is_lvl(int i);
    return i >= 4;
  endfunction

  task automatic m_lvl_check(int i);
    if (m_pri[i] != 255 && m_asr[i] && !m_snt[i]) begin
      m_snt[i] = 1; m_req[i] = 1;
    end
  endtask

  task automatic m_write(int i, int s, int p, int sv);
    m_srv[i] = s; m_pri[i] = p; m_sav[i] = sv;
    if (is_lvl(i)) m_lvl_check(i);
    else if (m_mp[i] && p != 255) begin m_mp[i] = 0; m_req[i] = 1; end
  endtask

  always @(posedge clk or negedge rst_n) begin : model
    int gi, n, li;
    bit ok;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_srv[i] = 0; m_pri[i] = 255; m_sav[i] = 255;
        m_rej[i] = 0; m_asr[i] = 0; m_snt[i] = 0; m_mp[i] = 0; m_req[i] = 0;
      end
      e_pv = 0; e_pnum = 0; e_psrv = 0; e_ppri = 0;
      e_rv = 0; e_rerr = 0; e_rsrv = 0; e_rpri = 0;
    end else begin
      gi = -1;
      for (int i = 0; i < 8; i++) if (m_req[i] && m_pri[i] == 255) m_req[i] = 0;
      for (int i = 7; i >= 0; i--) if (m_req[i]) gi = i;
      e_pv = 0; e_pnum = 0; e_psrv = 0; e_ppri = 0;
      if (gi >= 0) begin
        e_pv = 1; e_pnum = 16 + gi; e_psrv = m_srv[gi]; e_ppri = m_pri[gi]; m_req[gi] = 0;
      end
      e_rv = cmd_valid; e_rerr = 0; e_rsrv = 0; e_rpri = 0;
      if (cmd_valid) begin
        n = cmd_num; ok = (n >= 16 && n < 24); li = n - 16;
        case (cmd_op)
          2'd0: if (!ok || cmd_server >= 6 || cmd_prio > 255) e_rerr = 1;
                else m_write(li, cmd_server, cmd_prio, cmd_prio);
          2'd1: if (!ok) e_rerr = 1; else begin e_rsrv = m_srv[li]; e_rpri = m_pri[li]; end
          2'd2: if (!ok) e_rerr = 1; else m_write(li, m_srv[li], 255, m_pri[li]);
          default: if (!ok) e_rerr = 1; else m_write(li, m_srv[li], m_sav[li], m_sav[li]);
        endcase
      end else if (rej_valid) begin
        n = rej_num; li = n - 16;
        if (n >= 16 && n < 24) begin
          if (is_lvl(li)) m_snt[li] = 0; else m_rej[li] = 1;
        end
      end else if (eoi_valid) begin
        n = eoi_num; li = n - 16;
        if (n >= 16 && n < 24 && is_lvl(li)) begin
          m_snt[li] = 0;
          m_lvl_check(li);
        end
      end else if (evt_valid) begin
        li = evt_idx;
        if (is_lvl(li)) begin
          if (evt_level && !m_asr[li] && m_pri[li] != 255 && !m_snt[li]) begin
            m_snt[li] = 1; m_req[li] = 1;
          end
          m_asr[li] = evt_level;
        end else if (evt_level) begin
          if (m_pri[li] == 255) m_mp[li] = 1; else m_req[li] = 1;
        end
      end else if (resend_valid) begin
        for (int i = 0; i < 8; i++) begin
          if (is_lvl(i)) m_lvl_check(i);
          else if (m_rej[i]) begin
            m_rej[i] = 0;
            if (m_pri[i] != 255) m_req[i] = 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      n_chk++;
      if (pres_valid !== 1'(e_pv) || pres_num !== 10'(e_pnum) || pres_server !== 4'(e_psrv) ||
          pres_prio !== 8'(e_ppri) || rsp_valid !== 1'(e_rv) || rsp_err !== 1'(e_rerr) ||
          rsp_server !== 4'(e_rsrv) || rsp_prio !== 8'(e_rpri)) begin
        n_err++;
        $display("FAIL %s model: actual pres %0d/%0d/%0d/%0d rsp %0d/%0d/%0d/%0d expected pres %0d/%0d/%0d/%0d rsp %0d/%0d/%0d/%0d",
                 cur_tag, pres_valid, pres_num, pres_server, pres_prio, rsp_valid, rsp_err,
                 rsp_server, rsp_prio, e_pv, e_pnum, e_psrv, e_ppri, e_rv, e_rerr, e_rsrv, e_rpri);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle_all();
    evt_valid = 0; evt_idx = 0; evt_level = 0;
    cmd_valid = 0; cmd_op = 0; cmd_num = 0; cmd_server = 0; cmd_prio = 0;
    rej_valid = 0; rej_num = 0; eoi_valid = 0; eoi_num = 0; resend_valid = 0;
  endtask

  task automatic cmd(int op, int num, int srv, int pri);
    cmd_valid = 1; cmd_op = 2'(op); cmd_num = 10'(num); cmd_server = 4'(srv); cmd_prio = 9'(pri);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic ev(int idx, int lvl);
    evt_valid = 1; evt_idx = 3'(idx); evt_level = 1'(lvl);
    @(negedge clk);
    evt_valid = 0;
  endtask

  task automatic rej(int num);
    rej_valid = 1; rej_num = 10'(num);
    @(negedge clk);
    rej_valid = 0;
  endtask

  task automatic eoi(int num);
    eoi_valid = 1; eoi_num = 10'(num);
    @(negedge clk);
    eoi_valid = 0;
  endtask

  task automatic resend();
    resend_valid = 1;
    @(negedge clk);
    resend_valid = 0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic exp_pres(string tag, int v, int num, int srv, int pri);
    chk({tag, " pres_valid"}, pres_valid, v);
    if (v != 0) begin
      chk({tag, " pres_num"}, pres_num, num);
      chk({tag, " pres_server"}, pres_server, srv);
      chk({tag, " pres_prio"}, pres_prio, pri);
    end
  endtask

  task automatic exp_rsp(string tag, int err, int srv, int pri);
    chk({tag, " rsp_valid"}, rsp_valid, 1);
    chk({tag, " rsp_err"}, rsp_err, err);
    chk({tag, " rsp_server"}, rsp_server, srv);
    chk({tag, " rsp_prio"}, rsp_prio, pri);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    idle_all();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R2 reset pres_valid", pres_valid, 0);
    chk("R2 reset rsp_valid", rsp_valid, 0);
    rst_n = 1;
    cmp_on = 1;

    cur_tag = "R2"; cmd(1, 16, 0, 0); exp_rsp("R2 reset read", 0, 0, 255);
    cur_tag = "R1"; cmd(1, 24, 0, 0); exp_rsp("R1 above range", 1, 0, 0);
    cmd(1, 15, 0, 0); exp_rsp("R1 below range", 1, 0, 0);

    cur_tag = "R3"; ev(0, 1); tick(); exp_pres("R3 masked event", 0, 0, 0, 0);
    cur_tag = "R4"; cmd(0, 16, 2, 5); exp_rsp("R4 program ok", 0, 0, 0);
    tick(); exp_pres("R4 pending released", 1, 16, 2, 5);
    tick(); exp_pres("R4 only once", 0, 0, 0, 0);
    cur_tag = "R3"; ev(0, 1); tick(); exp_pres("R3 live event", 1, 16, 2, 5);

    cur_tag = "R7"; rej(16); tick(); exp_pres("R7 reject quiet", 0, 0, 0, 0);
    resend(); tick(); exp_pres("R7 msg resend", 1, 16, 2, 5);

    cur_tag = "R9"; cmd(0, 24, 0, 1); exp_rsp("R9 bad number", 1, 0, 0);
    cmd(0, 16, 6, 1); exp_rsp("R9 bad server", 1, 0, 0);
    cmd(0, 16, 1, 256); exp_rsp("R9 bad prio", 1, 0, 0);
    cmd(1, 16, 0, 0); exp_rsp("R9 unchanged", 0, 2, 5);

    cur_tag = "R10"; cmd(2, 16, 0, 0); exp_rsp("R10 mask ok", 0, 0, 0);
    cmd(1, 16, 0, 0); exp_rsp("R10 masked read", 0, 2, 255);
    ev(0, 1); tick(); exp_pres("R10 masked event held", 0, 0, 0, 0);
    cmd(3, 16, 0, 0); exp_rsp("R10 restore ok", 0, 0, 0);
    tick(); exp_pres("R10 restore presents", 1, 16, 2, 5);
    cmd(1, 16, 0, 0); exp_rsp("R10 restored read", 0, 2, 5);
    cmd(2, 30, 0, 0); exp_rsp("R10 mask bad number", 1, 0, 0);

    cur_tag = "R6"; cmd(0, 20, 1, 3); tick(); exp_pres("R6 level idle no pres", 0, 0, 0, 0);
    cur_tag = "R5"; ev(4, 1); tick(); exp_pres("R5 rising presents", 1, 20, 1, 3);
    ev(4, 1); tick(); exp_pres("R5 no repeat", 0, 0, 0, 0);
    cur_tag = "R8"; eoi(20); tick(); exp_pres("R8 eoi re-presents", 1, 20, 1, 3);
    cur_tag = "R7"; rej(20); tick(); exp_pres("R7 level reject quiet", 0, 0, 0, 0);
    resend(); tick(); exp_pres("R7 level resend", 1, 20, 1, 3);
    cur_tag = "R8"; ev(4, 0); eoi(20); tick(); exp_pres("R8 eoi deasserted", 0, 0, 0, 0);
    eoi(16); tick(); exp_pres("R8 msg eoi ignored", 0, 0, 0, 0);
    resend(); tick(); exp_pres("R8 resend after deassert", 0, 0, 0, 0);

    cur_tag = "R5"; ev(5, 1); tick(); exp_pres("R5 masked level", 0, 0, 0, 0);
    cur_tag = "R6"; cmd(0, 21, 4, 7); tick(); exp_pres("R6 program asserted", 1, 21, 4, 7);

    cur_tag = "R12"; cmd(0, 17, 3, 9); cmd(0, 18, 0, 2);
    rej(18); rej(17); resend(); tick(); exp_pres("R12 first lowest", 1, 17, 3, 9);
    tick(); exp_pres("R12 second next cycle", 1, 18, 0, 2);
    tick(); exp_pres("R12 queue empty", 0, 0, 0, 0);
    rej(17); rej(18); resend(); cmd(2, 18, 0, 0);
    exp_pres("R12 first of two", 1, 17, 3, 9);
    tick(); exp_pres("R12 masked pending dropped", 0, 0, 0, 0);

    cur_tag = "R13";
    cmd_valid = 1; cmd_op = 2'd1; cmd_num = 10'd16; rej_valid = 1; rej_num = 10'd16;
    @(negedge clk);
    cmd_valid = 0; rej_valid = 0;
    exp_rsp("R13 cmd serviced", 0, 2, 5);
    resend(); tick(); exp_pres("R13 reject ignored", 0, 0, 0, 0);

    cur_tag = "R10"; cmd(2, 17, 0, 0); cmd(2, 17, 0, 0); cmd(3, 17, 0, 0);
    cmd(1, 17, 0, 0); exp_rsp("R10 double mask loses prio", 0, 3, 255);

    cur_tag = "R13 random";
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 9);
      cmd_valid = (r < 3);
      rej_valid = (r == 3) || (r == 9);
      eoi_valid = (r == 4);
      evt_valid = (r >= 5 && r <= 7) || (r == 9);
      resend_valid = (r == 8) || (r == 9);
      cmd_op = 2'($urandom_range(0, 3));
      cmd_num = 10'($urandom_range(14, 25));
      cmd_server = 4'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) cmd_prio = 9'd255;
      else if ($urandom_range(0, 15) == 0) cmd_prio = 9'd256;
      else cmd_prio = 9'($urandom_range(0, 12));
      rej_num = 10'($urandom_range(15, 24));
      eoi_num = 10'($urandom_range(15, 24));
      evt_idx = 3'($urandom_range(0, 7));
      evt_level = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    idle_all();
    repeat (12) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule